// File: doc/BRIEF.md
# Bridge Interrupt Status and Mask Unit

This unit gathers the interrupt events of a bus bridge into two sticky status groups. The first is an eight-bit local status byte fed by local event pulses. The second is a four-flag PCI error group fed by error pulses. An eight-bit mask byte and a single global enable together decide whether pending local status raises the registered interrupt output `irq_o`. The PCI error flags do not drive `irq_o`. They are read and cleared through the same register port.

Every register is reached through a small byte/halfword register port. The port takes a byte address, a size select and a 16-bit data bus with natural byte lanes. Reads are combinational from the addressed aligned halfword. The two status groups clear in different ways. The local status byte clears completely when a zero is written to it. The PCI error flags clear bit by bit when a one is written to them, so software can write back the value it just read. The local status byte has no real states or transitions, only sticky bits, so no state machine is involved.

Top module: `bridge_irq_unit`

## Requirements
- R1: After reset the local status byte, the mask byte, the global enable, the PCI error flags, `irq_o` and every readable register are zero.
- R2: A one-cycle pulse on `local_evt[i]` sets bit i of the local status byte, which reads at byte offset 0. The bit layout is: 7 mailbox, 6 PCI read abort, 5 PCI write abort, 4 PCI pin interrupt, 3 PCI parity error, 2 inbound queue write, 1 DMA channel 1, 0 DMA channel 0. A set bit stays set until it is cleared.
- R3: A write of 0x00 to the local status byte clears every pending bit. A write of any nonzero value to it has no effect.
- R4: A set and a clear that land on the same bit in the same cycle leave the bit set. This holds for both status groups.
- R5: The mask byte at byte offset 1 is read/write and uses the same bit layout as the local status byte.
- R6: The global enable is bit 10 of the halfword at offset 2. All other bits of that halfword read zero. While the enable is zero, `irq_o` stays low.
- R7: The PCI error flags read in the halfword at offset 4: bit 15 parity error, 14 system error, 13 master abort, 12 target abort. `pci_err_evt[3:0]` sets bits 15 down to 12 in that order. All other bits read zero.
- R8: Writing a 1 to a PCI error flag clears it. Writing a 0 leaves it unchanged.
- R9: `irq_o` is registered. On each clock edge it takes the OR over all bits of (local status AND mask), gated by the global enable, using the values held before that edge.
- R10: A halfword write at an even address writes both byte lanes. A byte write uses `reg_wdata[7:0]` at an even address and `reg_wdata[15:8]` at an odd address. A halfword write at an odd address is ignored. Addresses 6 and above read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte address |
| reg_half | input | 1 | 1 = halfword access, 0 = byte access |
| reg_wdata | input | 16 | Write data on natural byte lanes |
| reg_rdata | output | 16 | Read data of the addressed aligned halfword |
| local_evt | input | 8 | Local event pulses, one per status bit |
| pci_err_evt | input | 4 | PCI error pulses: 3 parity, 2 system, 1 master abort, 0 target abort |
| irq_o | output | 1 | Registered local interrupt |

## Verification
The hardest situation to reach from the ports is a source pulse that arrives in exactly the cycle a clearing write reaches the same bit. The zero-write clear of the local byte and the write-one clear of the PCI flags both have to lose to that pulse. Directed steps line the pulse up with the write in the same cycle for both groups. Long random runs mix sparse event pulses with writes of random size, lane and data, and about a quarter of those writes carry zero data. The one-cycle lag of `irq_o` is checked right after the enable and the mask change, and right after a halfword write that clears both status and mask at once.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;

    typedef enum logic {
        CLR_ON_ZERO = 1'b0,
        CLR_ON_ONE  = 1'b1
    } clr_mode_e;

    localparam int LSTAT_W  = 8;
    localparam int PERR_W   = 4;
    localparam int DATA_W   = 16;
    localparam int EN_BIT   = 10;
    localparam int PERR_LSB = 12;

    localparam int WORD_STAT = 0;
    localparam int WORD_CFG  = 1;
    localparam int WORD_PERR = 2;

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
    import bridge_irq_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter clr_mode_e MODE  = CLR_ON_ZERO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] stat_o
);

    logic [WIDTH-1:0] clr_vec;
    logic [WIDTH-1:0] stat_q;

    generate
        if (MODE == CLR_ON_ZERO) begin : g_zero
            always_comb begin
                clr_vec = '0;
                if (wr_i && (wdata_i == '0)) begin
                    clr_vec = '1;
                end
            end

            p_zero_clear_r3 : assert property (@(posedge clk) disable iff (!rst_n)
                (wr_i && wdata_i == '0 && set_i == '0) |=> (stat_o == '0));

            p_nonzero_keep_r3 : assert property (@(posedge clk) disable iff (!rst_n)
                (wr_i && wdata_i != '0) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
        end else begin : g_one
            always_comb begin
                clr_vec = '0;
                if (wr_i) begin
                    clr_vec = wdata_i;
                end
            end

            p_w1c_r8 : assert property (@(posedge clk) disable iff (!rst_n)
                wr_i |=> ((stat_o & $past(wdata_i & ~set_i)) == '0));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_i;
        end
    end

    assign stat_o = stat_q;

    p_set_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

    p_sticky_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import bridge_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               half_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [LSTAT_W-1:0] lstat_i,
    input  logic [LSTAT_W-1:0] mask_i,
    input  logic               en_i,
    input  logic [PERR_W-1:0]  perr_i,
    output logic               lstat_wr_o,
    output logic [LSTAT_W-1:0] lstat_wd_o,
    output logic               mask_wr_o,
    output logic [LSTAT_W-1:0] mask_wd_o,
    output logic               en_wr_o,
    output logic               en_wd_o,
    output logic               perr_wr_o,
    output logic [PERR_W-1:0]  perr_wd_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int WORD_W = ADDR_W - 1;
    localparam int HI_LSB = DATA_W / 2;

    logic [WORD_W-1:0] word;
    logic              lane_lo;
    logic              lane_hi;
    logic [7:0]        byte_lo;
    logic [7:0]        byte_hi;

    assign word    = addr_i[ADDR_W-1:1];
    assign lane_lo = wr_i && !addr_i[0];
    assign lane_hi = wr_i && (half_i ? !addr_i[0] : addr_i[0]);
    assign byte_lo = wdata_i[7:0];
    assign byte_hi = wdata_i[15:8];

    assign lstat_wr_o = lane_lo && (word == WORD_W'(WORD_STAT));
    assign lstat_wd_o = byte_lo;
    assign mask_wr_o  = lane_hi && (word == WORD_W'(WORD_STAT));
    assign mask_wd_o  = byte_hi;
    assign en_wr_o    = lane_hi && (word == WORD_W'(WORD_CFG));
    assign en_wd_o    = byte_hi[EN_BIT-HI_LSB];
    assign perr_wr_o  = lane_hi && (word == WORD_W'(WORD_PERR));
    assign perr_wd_o  = byte_hi[PERR_LSB-HI_LSB +: PERR_W];

    always_comb begin
        rdata_o = '0;
        if (word == WORD_W'(WORD_STAT)) begin
            rdata_o = {mask_i, lstat_i};
        end else if (word == WORD_W'(WORD_CFG)) begin
            rdata_o[EN_BIT] = en_i;
        end else if (word == WORD_W'(WORD_PERR)) begin
            rdata_o[PERR_LSB +: PERR_W] = perr_i;
        end
    end

endmodule

// File: rtl/bridge_irq_unit.sv
module bridge_irq_unit
    import bridge_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_half,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [LSTAT_W-1:0] local_evt,
    input  logic [PERR_W-1:0]  pci_err_evt,
    output logic               irq_o
);

    logic               lstat_wr;
    logic [LSTAT_W-1:0] lstat_wd;
    logic               mask_wr;
    logic [LSTAT_W-1:0] mask_wd;
    logic               en_wr;
    logic               en_wd;
    logic               perr_wr;
    logic [PERR_W-1:0]  perr_wd;
    logic [LSTAT_W-1:0] lstat;
    logic [PERR_W-1:0]  perr;
    logic [LSTAT_W-1:0] mask_q;
    logic               en_q;
    logic               irq_q;

    irq_reg_port #(.ADDR_W(ADDR_W)) u_port (
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .half_i     (reg_half),
        .wdata_i    (reg_wdata),
        .lstat_i    (lstat),
        .mask_i     (mask_q),
        .en_i       (en_q),
        .perr_i     (perr),
        .lstat_wr_o (lstat_wr),
        .lstat_wd_o (lstat_wd),
        .mask_wr_o  (mask_wr),
        .mask_wd_o  (mask_wd),
        .en_wr_o    (en_wr),
        .en_wd_o    (en_wd),
        .perr_wr_o  (perr_wr),
        .perr_wd_o  (perr_wd),
        .rdata_o    (reg_rdata)
    );

    irq_stat_bank #(.WIDTH(LSTAT_W), .MODE(CLR_ON_ZERO)) u_local (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (local_evt),
        .wr_i    (lstat_wr),
        .wdata_i (lstat_wd),
        .stat_o  (lstat)
    );

    irq_stat_bank #(.WIDTH(PERR_W), .MODE(CLR_ON_ONE)) u_perr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (pci_err_evt),
        .wr_i    (perr_wr),
        .wdata_i (perr_wd),
        .stat_o  (perr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (mask_wr) begin
                mask_q <= mask_wd;
            end
            if (en_wr) begin
                en_q <= en_wd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= en_q && (|(lstat & mask_q));
        end
    end

    assign irq_o = irq_q;

    p_irq_gate_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_q));

    p_irq_source_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(lstat & mask_q)));

    p_odd_half_ignored_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_half && reg_addr[0]) |=> (mask_q == $past(mask_q) && en_q == $past(en_q)));

endmodule

// File: tb/sim_bridge_irq_unit.sv
module sim_bridge_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_half = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  local_evt = '0;
    logic [3:0]  pci_err_evt = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] ls_m = '0;
    logic [7:0] mk_m = '0;
    logic       en_m = 1'b0;
    logic [3:0] pe_m = '0;
    logic       irq_m = 1'b0;

    always #5 clk = ~clk;

    bridge_irq_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_half    (reg_half),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .local_evt   (local_evt),
        .pci_err_evt (pci_err_evt),
        .irq_o       (irq_o)
    );

    function automatic logic [15:0] rd_model(input logic [3:0] a);
        case (a[3:1])
            3'd0:    return {mk_m, ls_m};
            3'd1:    return {5'b0, en_m, 10'b0};
            3'd2:    return {pe_m, 12'b0};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a[3:1])
            3'd0:    return "R2 R5 read";
            3'd1:    return "R6 read";
            3'd2:    return "R7 read";
            default: return "R10 read";
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_edge(input logic w, input logic [3:0] a, input logic h,
                              input logic [15:0] d, input logic [7:0] le, input logic [3:0] pe);
        logic lo;
        logic hi;
        logic [7:0] ls_clr;
        logic [3:0] pe_clr;
        logic irq_n;
        irq_n  = en_m && (|(ls_m & mk_m));
        lo     = w && !a[0];
        hi     = w && (h ? !a[0] : a[0]);
        ls_clr = (lo && a[3:1] == 3'd0 && d[7:0] == 8'h00) ? 8'hFF : 8'h00;
        pe_clr = (hi && a[3:1] == 3'd2) ? d[15:12] : 4'h0;
        if (hi && a[3:1] == 3'd0) mk_m = d[15:8];
        if (hi && a[3:1] == 3'd1) en_m = d[10];
        ls_m  = (ls_m & ~ls_clr) | le;
        pe_m  = (pe_m & ~pe_clr) | pe;
        irq_m = irq_n;
    endtask

    task automatic step(input logic w, input logic [3:0] a, input logic h,
                        input logic [15:0] d, input logic [7:0] le, input logic [3:0] pe);
        @(negedge clk);
        reg_wr      = w;
        reg_addr    = a;
        reg_half    = h;
        reg_wdata   = d;
        local_evt   = le;
        pci_err_evt = pe;
        @(posedge clk);
        model_edge(w, a, h, d, le, pe);
        #2;
        chk("R9 irq", {15'b0, irq_o}, {15'b0, irq_m});
        chk(rd_tag(a), reg_rdata, rd_model(a));
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2;
        chk("R1 irq", {15'b0, irq_o}, 16'h0);
        chk("R1 status", reg_rdata, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 4'd2, 1, 16'h0, 8'h00, 4'h0);
        chk("R1 cfg", reg_rdata, 16'h0000);
        step(0, 4'd4, 1, 16'h0, 8'h00, 4'h0);
        chk("R1 perr", reg_rdata, 16'h0000);

        step(0, 4'd0, 1, 16'h0, 8'h20, 4'h0);
        chk("R2 set bit5", reg_rdata, 16'h0020);
        step(1, 4'd0, 0, 16'h00FF, 8'h00, 4'h0);
        chk("R3 nonzero ignored", reg_rdata, 16'h0020);
        step(1, 4'd0, 0, 16'h0000, 8'h00, 4'h0);
        chk("R3 zero clears", reg_rdata, 16'h0000);

        step(0, 4'd0, 0, 16'h0, 8'h20, 4'h0);
        step(1, 4'd0, 0, 16'h0000, 8'h22, 4'h0);
        chk("R4 local set wins", reg_rdata, 16'h0022);
        step(1, 4'd4, 1, 16'hF000, 8'h00, 4'b1000);
        chk("R4 perr set wins", reg_rdata, 16'h8000);
        step(0, 4'd4, 1, 16'h0, 8'h00, 4'b0011);
        chk("R7 flags", reg_rdata, 16'hB000);
        step(1, 4'd5, 0, 16'h8000, 8'h00, 4'h0);
        chk("R8 w1c odd byte", reg_rdata, 16'h3000);
        step(1, 4'd4, 1, 16'h0000, 8'h00, 4'h0);
        chk("R8 zero keeps", reg_rdata, 16'h3000);

        step(1, 4'd1, 0, 16'h0200, 8'h00, 4'h0);
        chk("R5 mask", reg_rdata, 16'h0222);
        step(0, 4'd0, 0, 16'h0, 8'h00, 4'h0);
        chk("R6 disabled", {15'b0, irq_o}, 16'h0);
        step(1, 4'd2, 1, 16'h0400, 8'h00, 4'h0);
        chk("R6 enable", reg_rdata, 16'h0400);
        chk("R9 lag", {15'b0, irq_o}, 16'h0);
        step(0, 4'd2, 1, 16'h0, 8'h00, 4'h0);
        chk("R9 raised", {15'b0, irq_o}, 16'h1);
        step(1, 4'd3, 1, 16'h0000, 8'h00, 4'h0);
        chk("R10 odd half ignored", reg_rdata, 16'h0400);
        step(1, 4'd0, 1, 16'h0000, 8'h00, 4'h0);
        chk("R10 half clears both", reg_rdata, 16'h0000);
        chk("R9 still high", {15'b0, irq_o}, 16'h1);
        step(0, 4'd0, 1, 16'h0, 8'h00, 4'h0);
        chk("R9 dropped", {15'b0, irq_o}, 16'h0);
        step(1, 4'd6, 1, 16'hFFFF, 8'h00, 4'h0);
        chk("R10 unmapped", reg_rdata, 16'h0000);

        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [3:0]  a;
            logic        h;
            logic [15:0] d;
            logic [7:0]  le;
            logic [3:0]  pe;
            w  = ($urandom % 3) == 0;
            a  = 4'($urandom % 8);
            h  = 1'($urandom % 2);
            d  = (($urandom % 4) == 0) ? 16'h0 : 16'($urandom);
            le = (($urandom % 5) == 0) ? 8'($urandom) : 8'h00;
            pe = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            step(w, a, h, d, le, pe);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule